// File: doc/BRIEF.md
# Serial Channel Control and Status Unit

This block holds the control and status state for one asynchronous serial channel. A CPU reaches it through a small register bus: one control register and one status register, read combinationally and written on a single-cycle strobe. It drives the enable lines and abort pulses toward the receive and transmit datapaths, and the request-to-send pin. It also holds the flags those datapaths report.

Turning a direction off aborts whatever that side is doing but leaves its flags alone, so software can still inspect them. One control bit does two jobs. Writing 0 to it wipes every receive error flag at once. Reading it in multiprocessor mode returns the address/data marker bit of the last frame received. An I/O stop input forces both directions off for as long as it is held.

Top module: `sio_ctrl`

## Requirements
- R1: After reset, receiver and transmitter are disabled, the request-to-send pin is high, all error flags and the receive-full flag are 0, and the transmit-empty flag is 1.
- R2: Control bit 6 is receiver enable, and `rx_en` follows it one cycle after the write. Reading the control register returns it in bit 6, with bits 7, 2, 1 and 0 reading 0.
- R3: When receiver enable falls, `rx_abort` is 1 for exactly one cycle. The receive-full flag and the error flags keep their values.
- R4: Control bit 5 is transmitter enable. When it falls, `tx_abort` is 1 for exactly one cycle, and the transmit-empty flag keeps its value.
- R5: While `io_halt` is 1, both enables are 0 and writes cannot set them. Dropping an enable through `io_halt` also gives the one-cycle abort pulse.
- R6: Control bit 4 drives `rts` directly. The new value appears on the pin in the cycle after the write.
- R7: When `mp_mode` is 1, control bit 3 reads back the multiprocessor bit captured with the most recent received byte. When `mp_mode` is 0, bit 3 reads 0.
- R8: Writing the control register with bit 3 at 0 clears the overrun, framing and parity flags together. Writing bit 3 at 1 leaves them unchanged.
- R9: Each error flag is set by a one-cycle pulse on its input. A set pulse wins over a clear write in the same cycle.
- R10: The receive-full flag is set by `rx_byte` and cleared by `rd_strobe`. A set wins when both arrive together.
- R11: The transmit-empty flag is cleared by `tx_load` and set by `tx_sent`. A set wins when both arrive together.
- R12: The status register reads as follows: bit 7 is receive-full, bit 6 overrun, bit 5 framing, bit 4 parity, bit 0 transmit-empty, and the other bits are 0. Any address other than the two registers reads 0. `err_flags` is {overrun, framing, parity}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_halt | input | 1 | I/O stop, forces both enables off |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rd_strobe | input | 1 | Receive data was read, clears receive-full |
| mp_mode | input | 1 | Multiprocessor mode enable |
| rx_byte | input | 1 | Byte received strobe |
| rx_mpb | input | 1 | Multiprocessor bit of the received byte |
| ovr_set | input | 1 | Overrun error pulse |
| frm_set | input | 1 | Framing error pulse |
| par_set | input | 1 | Parity error pulse |
| tx_load | input | 1 | Transmit data written, clears transmit-empty |
| tx_sent | input | 1 | Transmit buffer drained, sets transmit-empty |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rts | output | 1 | Request-to-send pin |
| rx_abort | output | 1 | One-cycle receive abort |
| tx_abort | output | 1 | One-cycle transmit abort |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit-empty flag |
| err_flags | output | 3 | {overrun, framing, parity} |

## Verification
The bench uses the default parameters: a 2-bit address with the control register at 0 and the status register at 1. With only four addresses, every one of them can be read back, including the two unused ones. All 256 control bytes are written in turn, so every enable edge and every abort pulse comes up in sequence. For the error logic, every pattern of set pulses is combined with both values of the clear bit, which covers all set-versus-clear collisions.

// File: rtl/sio_ctrl.sv
module sio_ctrl #(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_halt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rd_strobe,
  input  logic              mp_mode,
  input  logic              rx_byte,
  input  logic              rx_mpb,
  input  logic              ovr_set,
  input  logic              frm_set,
  input  logic              par_set,
  input  logic              tx_load,
  input  logic              tx_sent,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rts,
  output logic              rx_abort,
  output logic              tx_abort,
  output logic              rx_full,
  output logic              tx_empty,
  output logic [2:0]        err_flags
);
  localparam int RE_BIT  = 6;
  localparam int TE_BIT  = 5;
  localparam int RTS_BIT = 4;
  localparam int MP_BIT  = 3;

  logic ctrl_wr, err_clr, rx_en_d, tx_en_d, mpb_q;
  logic [2:0] err_in;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign err_clr = ctrl_wr && !bus_wdata[MP_BIT];
  assign err_in  = {ovr_set, frm_set, par_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
      rts   <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        rx_en <= bus_wdata[RE_BIT];
        tx_en <= bus_wdata[TE_BIT];
        rts   <= bus_wdata[RTS_BIT];
      end
      if (io_halt) begin
        rx_en <= 1'b0;
        tx_en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_d   <= 1'b0;
      tx_en_d   <= 1'b0;
      mpb_q     <= 1'b0;
      err_flags <= 3'b000;
      rx_full   <= 1'b0;
      tx_empty  <= 1'b1;
    end else begin
      rx_en_d   <= rx_en;
      tx_en_d   <= tx_en;
      if (rx_byte) mpb_q <= rx_mpb;
      err_flags <= err_in | (err_clr ? 3'b000 : err_flags);
      rx_full   <= rx_byte | (rx_full & ~rd_strobe);
      tx_empty  <= tx_sent | (tx_empty & ~tx_load);
    end
  end

  assign rx_abort = rx_en_d & ~rx_en;
  assign tx_abort = tx_en_d & ~tx_en;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[RE_BIT]  = rx_en;
      bus_rdata[TE_BIT]  = tx_en;
      bus_rdata[RTS_BIT] = rts;
      bus_rdata[MP_BIT]  = mp_mode & mpb_q;
    end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
      bus_rdata = {rx_full, err_flags, 3'b000, tx_empty};
    end
  end
endmodule

module sio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_halt,
  input logic       rd_strobe,
  input logic       rx_byte,
  input logic       ovr_set,
  input logic       frm_set,
  input logic       par_set,
  input logic       tx_load,
  input logic       tx_sent,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rx_abort,
  input logic       tx_abort,
  input logic       rx_full,
  input logic       tx_empty,
  input logic [2:0] err_flags
);
  p_halt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_halt |=> (!rx_en && !tx_en));
  p_rx_abort_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> ($past(rx_en) && !rx_en));
  p_rx_abort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort);
  p_tx_abort_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort && !$past(rx_byte) && !$past(rd_strobe)) |-> $stable(rx_full));
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && !$past(tx_load) && !$past(tx_sent)) |-> $stable(tx_empty));
  p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> err_flags[2]);
  p_par_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_set |=> err_flags[0]);
  p_full_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte |=> rx_full);
  p_empty_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sent |=> tx_empty);
endmodule

bind sio_ctrl sio_ctrl_chk u_chk (.*);

// File: tb/sim_sio_ctrl.sv
module sim_sio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_halt = 0, bus_wr = 0, rd_strobe = 0, mp_mode = 0, rx_byte = 0, rx_mpb = 0;
  logic ovr_set = 0, frm_set = 0, par_set = 0, tx_load = 0, tx_sent = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic rx_en, tx_en, rts, rx_abort, tx_abort, rx_full, tx_empty;
  logic [2:0] err_flags;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sio_ctrl u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = v; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic prev_re, prev_te;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_en", rx_en, 0); chk("R1 tx_en", tx_en, 0); chk("R1 rts", rts, 1);
    chk("R1 errs", err_flags, 0); chk("R1 full", rx_full, 0); chk("R1 empty", tx_empty, 1);
    rd(2'd1, d); chk("R12 status reset", d, 8'h01);
    rd(2'd2, d); chk("R12 unused addr 2", d, 0);
    rd(2'd3, d); chk("R12 unused addr 3", d, 0);

    // R2 R4 R6 sweep of every control byte
    prev_re = 0; prev_te = 0;
    for (int v = 0; v < 256; v++) begin
      wr_ctrl(8'(v));
      chk("R2 rx_en", rx_en, v[6]);
      chk("R4 tx_en", tx_en, v[5]);
      chk("R6 rts", rts, v[4]);
      chk("R3 rx_abort", rx_abort, prev_re & ~v[6]);
      chk("R4 tx_abort", tx_abort, prev_te & ~v[5]);
      rd(2'd0, d);
      chk("R2 ctrl read", d, v & 8'h70);
      @(negedge clk);
      chk("R3 abort single", rx_abort, 0);
      chk("R4 abort single", tx_abort, 0);
      prev_re = v[6]; prev_te = v[5];
    end

    // R3 R4 flags held across disable
    wr_ctrl(8'h68);
    @(negedge clk); rx_byte = 1; ovr_set = 1; tx_load = 1;
    @(negedge clk); rx_byte = 0; ovr_set = 0; tx_load = 0;
    wr_ctrl(8'h08);
    chk("R3 abort on disable", rx_abort, 1);
    chk("R3 full held", rx_full, 1);
    chk("R3 errs held", err_flags, 3'b100);
    chk("R4 empty held", tx_empty, 0);
    rd(2'd1, d); chk("R12 status layout", d, 8'hC0);

    // R5 halt forces enables off, writes ignored
    wr_ctrl(8'h60);
    @(negedge clk); io_halt = 1;
    @(negedge clk);
    chk("R5 rx off", rx_en, 0); chk("R5 tx off", tx_en, 0);
    chk("R5 rx_abort", rx_abort, 1); chk("R5 tx_abort", tx_abort, 1);
    wr_ctrl(8'h68);
    chk("R5 write blocked rx", rx_en, 0); chk("R5 write blocked tx", tx_en, 0);
    io_halt = 0;
    wr_ctrl(8'h68);
    chk("R5 enable after halt", rx_en, 1);

    // R7 multiprocessor bit readback
    for (int b = 0; b < 2; b++) begin
      @(negedge clk); rx_byte = 1; rx_mpb = b[0];
      @(negedge clk); rx_byte = 0; rx_mpb = 0;
      mp_mode = 1; rd(2'd0, d); chk("R7 mpb mode on", d[3], b);
      mp_mode = 0; rd(2'd0, d); chk("R7 mpb mode off", d[3], 0);
    end

    // R8 R9 clear versus set collisions
    for (int c = 0; c < 2; c++)
      for (int q = 0; q < 8; q++) begin
        @(negedge clk); {ovr_set, frm_set, par_set} = 3'b111;
        @(negedge clk); {ovr_set, frm_set, par_set} = 3'(q);
        bus_addr = 0; bus_wdata = c[0] ? 8'h08 : 8'h00; bus_wr = 1;
        @(negedge clk); bus_wr = 0; {ovr_set, frm_set, par_set} = 0;
        chk(c[0] ? "R8 keep on bit3=1" : "R9 set wins over clear", err_flags, c[0] ? 7 : q);
      end

    // R10 R11 flag set/clear combinations
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); rx_byte = 0; rd_strobe = 1; tx_sent = 0; tx_load = 1;
      @(negedge clk); rx_byte = p[0]; rd_strobe = p[1]; tx_sent = p[0]; tx_load = p[1];
      @(negedge clk); rx_byte = 0; rd_strobe = 0; tx_sent = 0; tx_load = 0;
      chk("R10 rx_full", rx_full, p[0]);
      chk("R11 tx_empty", tx_empty, p[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule